// File: doc/BRIEF.md
# Receive Sampling Delay Tuner

This controller picks the receive sampling delay of an SD host running a UHS-I bus in SDR50 or SDR104 mode. After a start pulse it sweeps a 7-bit delay code upward from 0 to 127. For each code it writes a delay-control register, then asks an external command engine to run one tuning transfer. The engine compares the 64-byte block the card returns against the known tuning pattern and reports a single pass or fail bit back to the controller.

While sweeping, the controller follows the current run of consecutive passing codes and keeps the longest run seen so far. When the sweep ends it programs the truncated centre of that run into the register. A sweep with no passing code, or one whose centre works out to zero, is treated as unusable. Such a sweep is repeated from scratch, up to three sweeps in all, and a failure pulse is raised after the last one.

The register image keeps every bit the caller supplied at start except the low fourteen. The delay code is written into bits [6:0] and bits [13:7], and it is also OR-ed into the field starting at bit 16.

Top module: `rxdly_tune`

## Requirements
- R1: Each sweep issues exactly 128 trial requests, with the delay codes 0, 1, ... 127 in ascending order, and exactly one request per code.
- R2: Whenever a trial is requested, and after a successful finish, `cfg_reg` equals (`cfg_init` AND NOT 0x3FFF) OR d OR (d << 7) OR (d << 16), where d is the current or selected 7-bit delay code and `cfg_init` is the value captured at start.
- R3: The register is written one cycle before `trial_req` rises. `trial_req`, `trial_dly` and `cfg_reg` then stay unchanged until the cycle in which `trial_done` is high, and `trial_req` is low in the cycle after that.
- R4: A closed run replaces the best run only if its length is strictly greater than the best so far, so the earliest of two runs of equal length wins.
- R5: The selected code is (first + last) / 2 of the best run, with the fraction dropped.
- R6: A run still open when code 127 passes competes with the best run under the same strict rule.
- R7: A sweep succeeds only if at least one trial passed and the selected code is non-zero. On success `done` is high for exactly one cycle, `busy` falls in that same cycle, and `done` and `fail` are never high together.
- R8: An unusable sweep restarts the sweep at code 0 with all run tracking cleared. After the third unusable sweep, `fail` pulses for one cycle without any further trials.
- R9: `start` is accepted only while idle, and `busy` is high from the next cycle. A `start` pulse during a sweep has no effect on the sequence of trials.
- R10: A synchronous reset puts the block into idle within one clock, with `cfg_reg` at zero and `busy`, `trial_req`, `done` and `fail` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begin tuning (accepted when idle) |
| cfg_init | input | 32 | Current register contents; bits above 13 are kept |
| trial_req | output | 1 | Request one tuning transfer at `trial_dly` |
| trial_dly | output | 7 | Delay code under test |
| trial_done | input | 1 | Transfer finished, `trial_pass` valid |
| trial_pass | input | 1 | Returned block matched the pattern |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse: tuning succeeded |
| fail | output | 1 | One-cycle pulse: all sweeps unusable |
| cfg_reg | output | 32 | Delay-control register image |

## Verification
The assertions check, on every cycle, the handshake hold rule, the ascending step of the delay code from one request to the next, the agreement between the low register fields and the requested code, the single-cycle `done` and `fail` pulses, and the reset and start behaviour. Whether the right window is chosen can only be shown by the bench's scenarios. These cover strict-greater tie breaking, truncation of the midpoint, a run left open at code 127, a zero midpoint forcing a retry, and success on a later sweep. Each scenario feeds a pass pattern and compares the final register and the number of sweeps against hand-computed values.

// File: rtl/rxdly_tune.sv
module rxdly_tune #(
  parameter int DW     = 7,
  parameter int SWEEPS = 3,
  parameter int RW     = 32,
  parameter int F2_LSB = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [RW-1:0] cfg_init,
  output logic          trial_req,
  output logic [DW-1:0] trial_dly,
  input  logic          trial_done,
  input  logic          trial_pass,
  output logic          busy,
  output logic          done,
  output logic          fail,
  output logic [RW-1:0] cfg_reg
);

  localparam int LW = DW + 1;
  localparam int CW = $clog2(SWEEPS + 1);
  localparam logic [DW-1:0] LAST = '1;
  localparam logic [RW-1:0] LOMASK = RW'((64'd1 << (2*DW)) - 64'd1);

  typedef enum logic [1:0] {S_IDLE, S_SET, S_REQ, S_EVAL} st_t;

  st_t           st;
  logic [DW-1:0] phase, run_start, best_mid;
  logic [LW-1:0] run_len, best_len;
  logic [CW-1:0] sweep;
  logic [RW-1:0] keep;
  logic          any_pass;

  function automatic logic [RW-1:0] pack(input logic [RW-1:0] k, input logic [DW-1:0] d);
    pack = k | RW'(d) | (RW'(d) << DW) | (RW'(d) << F2_LSB);
  endfunction

  logic [DW-1:0] open_start;
  logic [LW-1:0] sum_open, sum_closed, len_next;
  logic [DW-1:0] mid_open, mid_closed;

  assign open_start = (run_len == '0) ? phase : run_start;
  assign sum_open   = LW'(open_start) + LW'(phase);
  assign sum_closed = LW'(run_start) + LW'(DW'(phase - 1'b1));
  assign mid_open   = sum_open[LW-1:1];
  assign mid_closed = sum_closed[LW-1:1];
  assign len_next   = run_len + 1'b1;

  assign trial_req = (st == S_REQ);
  assign trial_dly = phase;
  assign busy      = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      st        <= S_IDLE;
      phase     <= '0;
      run_start <= '0;
      run_len   <= '0;
      best_len  <= '0;
      best_mid  <= '0;
      any_pass  <= 1'b0;
      sweep     <= '0;
      keep      <= '0;
      cfg_reg   <= '0;
      done      <= 1'b0;
      fail      <= 1'b0;
    end else begin
      done <= 1'b0;
      fail <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          keep      <= cfg_init & ~LOMASK;
          sweep     <= '0;
          phase     <= '0;
          run_start <= '0;
          run_len   <= '0;
          best_len  <= '0;
          best_mid  <= '0;
          any_pass  <= 1'b0;
          st        <= S_SET;
        end
        S_SET: begin
          cfg_reg <= pack(keep, phase);
          st      <= S_REQ;
        end
        S_REQ: if (trial_done) begin
          if (trial_pass) begin
            any_pass  <= 1'b1;
            run_start <= open_start;
            run_len   <= len_next;
            if (phase == LAST && len_next > best_len) begin
              best_mid <= mid_open;
              best_len <= len_next;
            end
          end else begin
            if (run_len > best_len) begin
              best_mid <= mid_closed;
              best_len <= run_len;
            end
            run_len <= '0;
          end
          if (phase == LAST) st <= S_EVAL;
          else begin
            phase <= phase + 1'b1;
            st    <= S_SET;
          end
        end
        S_EVAL: begin
          if (any_pass && best_mid != '0) begin
            cfg_reg <= pack(keep, best_mid);
            done    <= 1'b1;
            st      <= S_IDLE;
          end else if (sweep == CW'(SWEEPS - 1)) begin
            fail <= 1'b1;
            st   <= S_IDLE;
          end else begin
            sweep     <= sweep + 1'b1;
            phase     <= '0;
            run_start <= '0;
            run_len   <= '0;
            best_len  <= '0;
            best_mid  <= '0;
            any_pass  <= 1'b0;
            st        <= S_SET;
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/rxdly_tune_chk.sv
module rxdly_tune_chk #(
  parameter int DW = 7,
  parameter int RW = 32
) (
  input logic          clk,
  input logic          rst,
  input logic          start,
  input logic          busy,
  input logic          done,
  input logic          fail,
  input logic          trial_req,
  input logic          trial_done,
  input logic [DW-1:0] trial_dly,
  input logic [RW-1:0] cfg_reg
);

  logic [DW-1:0] next_dly;
  always_ff @(posedge clk) begin
    if (rst || !busy) next_dly <= '0;
    else if (trial_req && trial_done) next_dly <= trial_dly + 1'b1;
  end

  p_seq_step_r1: assert property (@(posedge clk) disable iff (rst)
    $rose(trial_req) |-> trial_dly == next_dly);

  p_low_fields_r2: assert property (@(posedge clk) disable iff (rst)
    trial_req |-> (cfg_reg[DW-1:0] == trial_dly && cfg_reg[2*DW-1:DW] == trial_dly));

  p_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (trial_req && !trial_done) |=> (trial_req && $stable(trial_dly) && $stable(cfg_reg)));

  p_drop_r3: assert property (@(posedge clk) disable iff (rst)
    (trial_req && trial_done) |=> !trial_req);

  p_pulse_done_r7: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  p_excl_r7: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, fail}));

  p_pulse_fail_r8: assert property (@(posedge clk) disable iff (rst)
    fail |=> !fail);

  p_start_r9: assert property (@(posedge clk) disable iff (rst)
    (start && !busy) |=> busy);

  p_idle_req_r9: assert property (@(posedge clk) disable iff (rst)
    !busy |-> !trial_req);

  p_reset_r10: assert property (@(posedge clk)
    rst |=> (cfg_reg == '0 && !busy && !done && !fail));

endmodule

bind rxdly_tune rxdly_tune_chk #(.DW(DW), .RW(RW)) u_chk (
  .clk(clk), .rst(rst), .start(start), .busy(busy), .done(done), .fail(fail),
  .trial_req(trial_req), .trial_done(trial_done), .trial_dly(trial_dly),
  .cfg_reg(cfg_reg)
);

// File: tb/rxdly_tune_tb.sv
module rxdly_tune_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] cfg_init = '0;
  logic        trial_req;
  logic [6:0]  trial_dly;
  logic        trial_done = 1'b0;
  logic        trial_pass = 1'b0;
  logic        busy, done, fail;
  logic [31:0] cfg_reg;

  always #(CLK_PERIOD/2) clk = ~clk;

  rxdly_tune dut_i (
    .clk(clk), .rst(rst), .start(start), .cfg_init(cfg_init),
    .trial_req(trial_req), .trial_dly(trial_dly),
    .trial_done(trial_done), .trial_pass(trial_pass),
    .busy(busy), .done(done), .fail(fail), .cfg_reg(cfg_reg)
  );

  typedef struct packed {
    logic [7:0] alo, ahi, blo, bhi, rlo, rhi;
    logic       ok;
    logic [6:0] dly;
    logic [1:0] sw;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VECS [NV] = '{
    '{8'd0,   8'd127, 8'd1,   8'd0,   8'd1,   8'd0,   1'b1, 7'd63,  2'd1},
    '{8'd10,  8'd20,  8'd40,  8'd60,  8'd1,   8'd0,   1'b1, 7'd50,  2'd1},
    '{8'd5,   8'd14,  8'd30,  8'd39,  8'd1,   8'd0,   1'b1, 7'd9,   2'd1},
    '{8'd100, 8'd127, 8'd20,  8'd29,  8'd1,   8'd0,   1'b1, 7'd113, 2'd1},
    '{8'd1,   8'd0,   8'd1,   8'd0,   8'd1,   8'd0,   1'b0, 7'd0,   2'd3},
    '{8'd0,   8'd1,   8'd1,   8'd0,   8'd0,   8'd0,   1'b0, 7'd0,   2'd3},
    '{8'd1,   8'd0,   8'd1,   8'd0,   8'd60,  8'd61,  1'b1, 7'd60,  2'd2},
    '{8'd127, 8'd127, 8'd1,   8'd0,   8'd1,   8'd0,   1'b1, 7'd127, 2'd1},
    '{8'd1,   8'd1,   8'd1,   8'd0,   8'd1,   8'd0,   1'b1, 7'd1,   2'd1},
    '{8'd0,   8'd2,   8'd1,   8'd0,   8'd1,   8'd0,   1'b1, 7'd1,   2'd1},
    '{8'd7,   8'd10,  8'd1,   8'd0,   8'd1,   8'd0,   1'b1, 7'd8,   2'd1},
    '{8'd0,   8'd49,  8'd60,  8'd70,  8'd1,   8'd0,   1'b1, 7'd24,  2'd1},
    '{8'd0,   8'd9,   8'd118, 8'd127, 8'd1,   8'd0,   1'b1, 7'd4,   2'd1},
    '{8'd1,   8'd0,   8'd1,   8'd0,   8'd0,   8'd1,   1'b0, 7'd0,   2'd3},
    '{8'd0,   8'd0,   8'd1,   8'd0,   8'd126, 8'd127, 1'b1, 7'd126, 2'd2}
  };

  int nchk = 0;
  int nfail = 0;

  task automatic chk(input bit c, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (!c) begin
      nfail++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_cfg(input logic [31:0] init, input logic [6:0] d);
    exp_cfg = (init & ~32'h3FFF) | {25'd0, d} | ({25'd0, d} << 7) | ({25'd0, d} << 16);
  endfunction

  function automatic bit in_win(input logic [7:0] lo, input logic [7:0] hi, input logic [6:0] d);
    in_win = ({1'b0, d} >= lo) && ({1'b0, d} <= hi);
  endfunction

  vec_t        cur_v;
  logic [31:0] cur_init;
  int          vidx = 0;
  bit          resp_en = 1'b0;
  logic [6:0]  exp_next;
  int          ntr, nsw;

  initial begin
    forever begin
      @(negedge clk);
      if (resp_en && trial_req) begin
        automatic logic [6:0] d = trial_dly;
        automatic int lat = (int'(d) + vidx) % 3;
        automatic bit p;
        if (d == 7'd0) nsw++;
        ntr++;
        chk(d == exp_next, "R1", "delay order", {25'd0, d}, {25'd0, exp_next});
        exp_next = d + 7'd1;
        chk(cfg_reg == exp_cfg(cur_init, d), "R2", "register at trial", cfg_reg, exp_cfg(cur_init, d));
        for (int k = 0; k < lat; k++) begin
          @(negedge clk);
          chk(trial_req && trial_dly == d && cfg_reg == exp_cfg(cur_init, d), "R3",
              "hold while waiting", cfg_reg, exp_cfg(cur_init, d));
        end
        p = (nsw <= 1) ? (in_win(cur_v.alo, cur_v.ahi, d) || in_win(cur_v.blo, cur_v.bhi, d))
                       : in_win(cur_v.rlo, cur_v.rhi, d);
        trial_done = 1'b1;
        trial_pass = p;
        @(negedge clk);
        trial_done = 1'b0;
        trial_pass = 1'b0;
        chk(!trial_req, "R3", "request drops after done", {31'd0, trial_req}, 32'd0);
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !trial_req && !done && !fail && cfg_reg == 32'd0, "R10", "reset state",
        cfg_reg, 32'd0);
    rst = 1'b0;
    @(negedge clk);

    // R3 / R9 / R10: stalled handshake, ignored start, reset mid-sweep
    cfg_init = 32'hFF80_FFFF;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy, "R9", "busy after start", {31'd0, busy}, 32'd1);
    @(negedge clk);
    chk(trial_req && trial_dly == 7'd0, "R3", "first request", {25'd0, trial_dly}, 32'd0);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(trial_req && trial_dly == 7'd0 && cfg_reg == exp_cfg(32'hFF80_FFFF, 7'd0), "R3",
          "stalled request held", cfg_reg, exp_cfg(32'hFF80_FFFF, 7'd0));
    end
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(!busy && !trial_req && cfg_reg == 32'd0, "R10", "reset mid-sweep", cfg_reg, 32'd0);
    @(negedge clk);

    resp_en = 1'b1;
    for (int i = 0; i < NV; i++) begin
      automatic int wait_n = 0;
      vidx = i;
      cur_v = VECS[i];
      cur_init = i[0] ? 32'h0012_3456 : 32'hFF80_FFFF;
      exp_next = 7'd0;
      ntr = 0;
      nsw = 0;
      cfg_init = cur_init;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      chk(busy, "R9", "busy after start", {31'd0, busy}, 32'd1);
      repeat (40) @(negedge clk);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (!done && !fail && wait_n < 5000) begin
        @(negedge clk);
        wait_n++;
      end
      if (cur_v.ok) begin
        chk(done && !fail, "R7", $sformatf("vector %0d succeeds", i), {30'd0, done, fail}, 32'd2);
        chk(cfg_reg == exp_cfg(cur_init, cur_v.dly), "R4",
            $sformatf("vector %0d window midpoint (R5 R6)", i), cfg_reg, exp_cfg(cur_init, cur_v.dly));
      end else begin
        chk(fail && !done, "R8", $sformatf("vector %0d fails", i), {30'd0, done, fail}, 32'd1);
      end
      chk(nsw == int'(cur_v.sw), "R8", $sformatf("vector %0d sweep count", i), nsw, {30'd0, cur_v.sw});
      chk(ntr == 128 * int'(cur_v.sw), "R1", $sformatf("vector %0d trial count", i), ntr,
          128 * int'(cur_v.sw));
      chk(!busy, "R7", "busy low at finish", {31'd0, busy}, 32'd0);
      @(negedge clk);
      chk(!done && !fail, "R7", "single-cycle pulse", {30'd0, done, fail}, 32'd0);
    end

    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule